// File: doc/BRIEF.md
# Pin Change Interrupt Monitor

This block watches a six-bit input port and raises a sticky change flag whenever an enabled pin no longer matches the value software last saw. The reference value is a snapshot. Any port read or port write by software reloads it from the synchronised pins. Because the comparison is made against that snapshot and not against the previous cycle, a change keeps setting the flag until software accesses the port. Only after that access can a flag-clear write take effect.

Each pin has its own enable bit in an enable register, which software writes and reads back. Two mode inputs adjust the view of that register. A crystal-oscillator mode hides bits 5:4 on readback. A wake-up mode, combined with sleep, removes pin 3 from detection. The flag is gated by a global interrupt enable to form an interrupt request. While the device sleeps, the flag also drives a wake request.

There are two resets. A power-on reset clears everything. A warm reset (external pin or brown-out) clears only the flag and leaves the snapshot and the enables untouched, so a mismatch that is still present sets the flag again straight after the reset is released.

Top module: `pin_change_monitor`

## Requirements
- R1: Each pin i in 5:0 takes part in detection only while enable bit i is 1; a change on a disabled pin never sets the flag.
- R2: While the power-on reset is asserted and after it, the enable readback is 8'h00 and the flag, interrupt request and wake request are 0 until new stimulus arrives.
- R3: A cycle with port read or port write strobe high loads the snapshot with the synchronised pins, which ends the mismatch from the next cycle.
- R4: On every clock edge where any enabled synchronised pin differs from its snapshot bit, and no port access occurs, the flag is set. A clear write in that cycle has no effect.
- R5: A flag-clear write clears the flag on the next edge when no mismatch is setting it.
- R6: A warm reset clears the flag but leaves the snapshot and the enable bits unchanged. Port accesses and enable writes are ignored while it is asserted. If a mismatch remains, the flag is set on the first edge after release.
- R7: The interrupt request equals the flag ANDed with the global enable, and the wake request equals the flag ANDed with the sleep input.
- R8: While the oscillator-mode input is 1 (crystal mode), enable readback bits 5:4 read 0. The stored bits are kept and reappear when the input returns to 0.
- R9: While both the wake-up-mode input and the sleep input are 1, enable bit 3 is treated as 0 for detection.
- R10: Enable readback bits 7:6 always read 0, whatever was written there.
- R11: A mismatch first seen in the same cycle as a port access is absorbed into the new snapshot and does not set the flag.
- R12: Pins pass through two synchronising flops, so a pin change made between edges sets the flag on the third rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_warm_n | input | 1 | Warm reset (pin or brown-out), synchronous, active low |
| pins_i | input | 6 | Asynchronous port pins |
| port_rd_i | input | 1 | Port read strobe |
| port_wr_i | input | 1 | Port write strobe |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register readback |
| flag_clr_i | input | 1 | Flag clear write strobe |
| sleep_i | input | 1 | Device is asleep |
| wake_mode_i | input | 1 | Wake-up mode active (masks pin 3 during sleep) |
| osc_xtal_i | input | 1 | Crystal oscillator mode selected |
| gie_i | input | 1 | Global interrupt enable |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The assertions take for granted that strobes and mode inputs are synchronous to the clock. Only the pins may change freely. They also assume the warm reset is a clean synchronous level. The stimulus drives every input on the falling edge, including the pins, so the synchronisers never see a transition at the sampling edge. It also keeps port and enable strobes low while the warm reset is held, matching a processor that is halted in reset.

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int W  = 6,
  parameter int RW = 8,
  parameter int WAKE_BIT = 3,
  parameter int XLO = 4,
  parameter int XHI = 5
) (
  input  logic          clk,
  input  logic          rst_por_n,
  input  logic          rst_warm_n,
  input  logic [W-1:0]  pins_i,
  input  logic          port_rd_i,
  input  logic          port_wr_i,
  input  logic          en_wr_i,
  input  logic [RW-1:0] en_wdata_i,
  output logic [RW-1:0] en_rdata_o,
  input  logic          flag_clr_i,
  input  logic          sleep_i,
  input  logic          wake_mode_i,
  input  logic          osc_xtal_i,
  input  logic          gie_i,
  output logic          flag_o,
  output logic          irq_o,
  output logic          wake_o
);

  localparam logic [W-1:0] XMASK = W'(((1 << (XHI - XLO + 1)) - 1) << XLO);
  localparam logic [W-1:0] WMASK = W'(1 << WAKE_BIT);

  logic [W-1:0] s1_q, s2_q, snap_q, en_q, en_eff, diff;
  logic         flag_q, access, mm;

  assign access = (port_rd_i | port_wr_i) & rst_warm_n;
  assign en_eff = en_q & ~((wake_mode_i & sleep_i) ? WMASK : '0);
  assign diff   = (s2_q ^ snap_q) & en_eff;
  assign mm     = |diff;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      snap_q <= '0;
      en_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      s1_q <= pins_i;
      s2_q <= s1_q;
      if (access) snap_q <= s2_q;
      if (en_wr_i && rst_warm_n) en_q <= en_wdata_i[W-1:0];
      if (!rst_warm_n) flag_q <= 1'b0;
      else             flag_q <= (flag_q & ~flag_clr_i) | (mm & ~access);
    end
  end

  assign en_rdata_o = RW'(en_q & ~(osc_xtal_i ? XMASK : '0));
  assign flag_o     = flag_q;
  assign irq_o      = flag_q & gie_i;
  assign wake_o     = flag_q & sleep_i;

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_por_n)
    rst_warm_n && mm && !access |=> flag_o);
  p_snap_r3: assert property (@(posedge clk) disable iff (!rst_por_n)
    access |=> snap_q == $past(s2_q));
  p_hold_snap_r6: assert property (@(posedge clk) disable iff (!rst_por_n)
    !access |=> $stable(snap_q));
  p_warm_r6: assert property (@(posedge clk) disable iff (!rst_por_n)
    !rst_warm_n |=> !flag_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_por_n)
    rst_warm_n && flag_clr_i && !mm |=> !flag_o);
  p_absorb_r11: assert property (@(posedge clk) disable iff (!rst_por_n)
    access && !flag_o |=> !flag_o);
  p_xtal_r8: assert property (@(posedge clk) disable iff (!rst_por_n)
    osc_xtal_i |-> en_rdata_o[XHI:XLO] == '0);
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_por_n)
    (!gie_i |-> !irq_o) and (!sleep_i |-> !wake_o));

endmodule

// File: tb/test_pin_change_monitor.sv
module test_pin_change_monitor;
  localparam int CLK_P = 10;

  logic clk = 0, rst_por_n = 0, rst_warm_n = 1;
  logic [5:0] pins = 0;
  logic rd = 0, wr = 0, en_wr = 0, clr = 0, sl = 0, wm = 0, xt = 0, gie = 0;
  logic [7:0] wdata = 0, rdata;
  logic flag, irq, wake;

  int total = 0, bad = 0;
  logic [5:0] ms1 = 0, ms2 = 0, msnap = 0, men = 0;
  logic mflag = 0;

  always #(CLK_P/2) clk = ~clk;

  pin_change_monitor i_pin_change_monitor (
    .clk(clk), .rst_por_n(rst_por_n), .rst_warm_n(rst_warm_n), .pins_i(pins),
    .port_rd_i(rd), .port_wr_i(wr), .en_wr_i(en_wr), .en_wdata_i(wdata),
    .en_rdata_o(rdata), .flag_clr_i(clr), .sleep_i(sl), .wake_mode_i(wm),
    .osc_xtal_i(xt), .gie_i(gie), .flag_o(flag), .irq_o(irq), .wake_o(wake));

  function automatic logic [7:0] exp_rd(logic [5:0] e, logic x);
    return {2'b00, e[5:4] & ~{2{x}}, e[3:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic acc, mm;
    logic [5:0] ee;
    @(posedge clk);
    acc = (rd | wr) & rst_warm_n;
    ee  = men & ~((wm & sl) ? 6'h08 : 6'h00);
    mm  = |((ms2 ^ msnap) & ee);
    if (!rst_warm_n) mflag = 0;
    else mflag = (mflag & ~clr) | (mm & ~acc);
    if (acc) msnap = ms2;
    if (en_wr && rst_warm_n) men = wdata[5:0];
    ms2 = ms1;
    ms1 = pins;
    @(negedge clk);
    chk("R4/R5 model flag", flag, mflag);
    chk("R7 model irq", irq, mflag & gie);
    chk("R7 model wake", wake, mflag & sl);
    chk("R8/R10 model readback", rdata, exp_rd(men, xt));
  endtask

  task automatic idle();
    rd = 0; wr = 0; en_wr = 0; clr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R2 reset readback", rdata, 8'h00);
    chk("R2 reset flag", flag, 0);
    rst_por_n = 1;
    cyc();
    chk("R2 after reset flag", flag, 0);

    en_wr = 1; wdata = 8'hFF; cyc(); idle();
    chk("R10 upper bits zero", rdata, 8'h3F);
    xt = 1; #1;
    chk("R8 crystal hides 5:4", rdata, 8'h0F);
    xt = 0; #1;
    chk("R8 bits return", rdata, 8'h3F);

    pins = 6'h01; cyc(); cyc();
    chk("R12 not yet after two edges", flag, 0);
    cyc();
    chk("R12 set on third edge", flag, 1);
    clr = 1; cyc(); idle();
    chk("R4 clear ignored under mismatch", flag, 1);
    rd = 1; cyc(); idle();
    chk("R3 flag held after read", flag, 1);
    clr = 1; cyc(); idle();
    chk("R5 clear after read", flag, 0);

    en_wr = 1; wdata = 8'h3E; cyc(); idle();
    pins = 6'h00; repeat (4) cyc();
    chk("R1 disabled pin ignored", flag, 0);
    wr = 1; cyc(); idle();

    pins = 6'h02; cyc(); cyc();
    rd = 1; cyc(); idle();
    chk("R11 change absorbed", flag, 0);
    cyc();
    chk("R11 still clear", flag, 0);

    pins = 6'h06; repeat (3) cyc();
    chk("R4 set on enabled change", flag, 1);
    rst_warm_n = 0; cyc();
    chk("R6 warm reset clears flag", flag, 0);
    rst_warm_n = 1; cyc();
    chk("R6 snapshot kept, flag back", flag, 1);
    chk("R6 enables kept", rdata, 8'h3E);

    gie = 1; #1;
    chk("R7 irq with gie", irq, 1);
    gie = 0; sl = 1; #1;
    chk("R7 irq gated", irq, 0);
    chk("R7 wake in sleep", wake, 1);
    rd = 1; cyc(); idle(); clr = 1; cyc(); idle();

    en_wr = 1; wdata = 8'h08; cyc(); idle();
    wm = 1; pins = 6'h0E; repeat (4) cyc();
    chk("R9 bit 3 masked in wake mode sleep", flag, 0);
    wm = 0; cyc();
    chk("R9 bit 3 active again", flag, 1);
    sl = 0; rd = 1; cyc(); idle(); clr = 1; cyc(); idle();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pins = 6'($urandom);
      rst_warm_n = ($urandom_range(40) != 0);
      rd    = rst_warm_n && ($urandom_range(7) == 0);
      wr    = rst_warm_n && ($urandom_range(11) == 0);
      en_wr = rst_warm_n && ($urandom_range(15) == 0);
      wdata = 8'($urandom);
      clr   = ($urandom_range(5) == 0);
      if ($urandom_range(20) == 0) sl  = ~sl;
      if ($urandom_range(20) == 0) wm  = ~wm;
      if ($urandom_range(20) == 0) xt  = ~xt;
      if ($urandom_range(10) == 0) gie = ~gie;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule